// File: doc/BRIEF.md
# Eight-Bit ALU with Stored Status Flags

This block is an 8-bit arithmetic logic unit with a 4-bit operation code. The result is purely combinational. Four status bits are kept in a register: zero, carry, negative and overflow. The register advances on the shared system clock when the flag write enable is high.

The operations are:
- pass-through of either operand and complement of either operand;
- add, add with the stored carry, and subtract;
- bitwise AND, OR and XOR;
- six single-bit shifts of operand A: logical, arithmetic and circular, each to the left and to the right.

Every operation updates only the flags that mean something for it. The other flags keep their stored value, so a later instruction can still test them.

The surrounding datapath feeds the operands and the operation code. It reads `result` in the same cycle. The flag outputs reflect the previous flag-writing operation.

Top module: `alu8_flags`

## Requirements
- R1: `result` follows the code in the same cycle for these operations: 0 gives A, 1 gives B, 2 gives ~A, 3 gives ~B, 7 gives A&B, 8 gives A|B and 9 gives A^B.
- R2: `result` is (A+B) mod 256 for code 4, (A+B+C) mod 256 for code 5, and (A-B) mod 256 for code 6. In code 5, C is the currently stored carry flag.
- R3: For codes 4 and 5, C is set to the unsigned carry out of bit 7. For code 6, C is set to the borrow, that is A<B unsigned.
- R4: For codes 4, 5 and 6, O is set when the two's-complement result lies outside -128..127.
- R5: The shifts of A give these results and carry values:
  - 10 is a left shift with 0 in: C is the old bit 7.
  - 11 is a right shift with 0 in: C is the old bit 0.
  - 12 is a left shift: C is the old bit 7.
  - 13 is a right shift that keeps bit 7: C is the old bit 0.
  - 14 is a left rotate: C is the old bit 7.
  - 15 is a right rotate: C is the old bit 0.
- R6: Code 12 sets O when bit 7 and bit 6 of A differ. Code 13 clears O.
- R7: On every flag write, Z is set exactly when `result` is zero, and N takes bit 7 of `result`.
- R8: Codes 0-3 and 7-9 leave C and O unchanged. Codes 10, 11, 14 and 15 leave O unchanged.
- R9: While `flag_we` is low, all four flags hold their values.
- R10: A synchronous `rst` clears all four flags on the next clock edge and takes priority over `flag_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 8 | Operand A |
| b | input | 8 | Operand B |
| fun_sel | input | 4 | Operation code |
| flag_we | input | 1 | Flag register write enable |
| result | output | 8 | Combinational result |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry/borrow flag |
| flag_n | output | 1 | Stored negative flag |
| flag_o | output | 1 | Stored overflow flag |

## Verification
The bench sweeps every operation code over all 256 values of A. B is paired from a set that includes 0, 0x7F, 0x80, 0xFF, A itself and ~A, so every subtract reaches a zero result and every add reaches both signed boundaries. The sweep catches the following faults:
- Subtract carry inverted: a design that stores the raw adder carry out instead of the borrow fails on every A>=B pair.
- Wrong carry feeding add-with-carry: a design that uses a fresh carry instead of the stored flag gives results off by one.
- Rotate faults: a rotate that goes through the carry drops the wrapped bit.
- Flag leakage: the bench keeps a model of the flags. A design that writes C or O on logic operations, or updates flags while the write enable is low, drifts away from that model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_PASS_A = 4'h0,
        OP_PASS_B = 4'h1,
        OP_INV_A  = 4'h2,
        OP_INV_B  = 4'h3,
        OP_ADD    = 4'h4,
        OP_ADC    = 4'h5,
        OP_SUB    = 4'h6,
        OP_AND    = 4'h7,
        OP_OR     = 4'h8,
        OP_XOR    = 4'h9,
        OP_LSL    = 4'hA,
        OP_LSR    = 4'hB,
        OP_ASL    = 4'hC,
        OP_ASR    = 4'hD,
        OP_ROL    = 4'hE,
        OP_ROR    = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic o;
    } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         c_in_eff;
    logic         c_out;

    always_comb begin
        b_eff    = sub ? ~b : b;
        c_in_eff = sub ? 1'b1 : cin;
        {c_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_in_eff};
        // subtract reports borrow, which is the inverse of the adder carry
        carry    = sub ? ~c_out : c_out;
        ovf      = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         sh_c,
    output logic         sh_o
);
    logic left;

    always_comb begin
        left = (op == OP_LSL) || (op == OP_ASL) || (op == OP_ROL);
        sh_c = left ? a[W-1] : a[0];
        sh_o = 1'b0;
        unique case (op)
            OP_LSL:  res = {a[W-2:0], 1'b0};
            OP_LSR:  res = {1'b0, a[W-1:1]};
            OP_ASL: begin
                res  = {a[W-2:0], 1'b0};
                sh_o = a[W-1] ^ a[W-2];
            end
            OP_ASR:  res = {a[W-1], a[W-1:1]};
            OP_ROL:  res = {a[W-2:0], a[W-1]};
            OP_ROR:  res = {a[0], a[W-1:1]};
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fun_sel,
    input  logic         flag_we,
    output logic [W-1:0] result,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_n,
    output logic         flag_o
);
    alu_op_e      op;
    alu_flags_t   flags_d, flags_q;
    logic [W-1:0] as_sum, sh_res;
    logic         as_carry, as_ovf, sh_c, sh_o;
    logic         is_sub, is_arith, is_shift;

    assign op     = alu_op_e'(fun_sel);
    assign is_sub = (op == OP_SUB);

    alu8_addsub #(.W(W)) u_addsub (
        .a     (a),
        .b     (b),
        .cin   ((op == OP_ADC) ? flags_q.c : 1'b0),
        .sub   (is_sub),
        .sum   (as_sum),
        .carry (as_carry),
        .ovf   (as_ovf)
    );

    alu8_shifter #(.W(W)) u_shift (
        .a    (a),
        .op   (op),
        .res  (sh_res),
        .sh_c (sh_c),
        .sh_o (sh_o)
    );

    always_comb begin
        is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB);
        is_shift = fun_sel >= 4'hA;
        unique case (op)
            OP_PASS_A: result = a;
            OP_PASS_B: result = b;
            OP_INV_A:  result = ~a;
            OP_INV_B:  result = ~b;
            OP_AND:    result = a & b;
            OP_OR:     result = a | b;
            OP_XOR:    result = a ^ b;
            OP_ADD, OP_ADC, OP_SUB: result = as_sum;
            default:   result = sh_res;
        endcase

        flags_d   = flags_q;
        flags_d.z = (result == '0);
        flags_d.n = result[W-1];
        if (is_arith) begin
            flags_d.c = as_carry;
            flags_d.o = as_ovf;
        end else if (is_shift) begin
            flags_d.c = sh_c;
            if (op == OP_ASL || op == OP_ASR) begin
                flags_d.o = sh_o;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (flag_we) begin
            flags_q <= flags_d;
        end
    end

    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_n = flags_q.n;
    assign flag_o = flags_q.o;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [3:0]   fun_sel,
    input logic         flag_we,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_n,
    input logic         flag_o
);
    logic keeps_co;
    assign keeps_co = (fun_sel <= 4'h3) || (fun_sel >= 4'h7 && fun_sel <= 4'h9);

    a_r1_pass_a: assert property (@(posedge clk) disable iff (rst)
        (fun_sel == 4'h0) |-> (result == a));

    a_r2_adc: assert property (@(posedge clk) disable iff (rst)
        (fun_sel == 4'h5) |-> (result == W'(a + b + {{(W-1){1'b0}}, flag_c})));

    a_r6_asr_clears_o: assert property (@(posedge clk) disable iff (rst)
        (flag_we && fun_sel == 4'hD) |=> !flag_o);

    a_r7_zero: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_z == ($past(result) == '0)));

    a_r7_neg: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_n == $past(result[W-1])));

    a_r8_keep_co: assert property (@(posedge clk) disable iff (rst)
        (flag_we && keeps_co) |=> (flag_c == $past(flag_c) && flag_o == $past(flag_o)));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable({flag_z, flag_c, flag_n, flag_o}));

    a_r10_reset: assert property (@(posedge clk)
        rst |=> ({flag_z, flag_c, flag_n, flag_o} == 4'b0000));
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a       (a),
    .b       (b),
    .fun_sel (fun_sel),
    .flag_we (flag_we),
    .result  (result),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .flag_n  (flag_n),
    .flag_o  (flag_o)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a = '0, b = '0;
    logic [3:0] fun_sel = '0;
    logic       flag_we = 1'b0;
    logic [7:0] result;
    logic       flag_z, flag_c, flag_n, flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mz, mc, mn, mo;

    always #2 clk = ~clk;

    alu8_flags u_dut (
        .clk(clk), .rst(rst), .a(a), .b(b), .fun_sel(fun_sel), .flag_we(flag_we),
        .result(result), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_o(flag_o)
    );

    function automatic int sg(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic int pick_b(input int av, input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 127;
            3: return 128;
            4: return 255;
            5: return 85;
            6: return 170;
            7: return av;
            8: return 255 - av;
            default: return (av * 37 + 11) % 256;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp,
                       input int op, input int av, input int bv);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (op=%0d a=%0d b=%0d)",
                     tag, act, exp, op, av, bv);
        end
    endtask

    task automatic step(input int op, input int av, input int bv, input bit we, input bit rs);
        int r, c, o, s;
        string rtag, ctag, otag, ztag;
        fun_sel = op[3:0]; a = av[7:0]; b = bv[7:0]; flag_we = we; rst = rs;
        #1;
        c = mc; o = mo;
        rtag = "R1"; ctag = "R8"; otag = "R8";
        case (op)
            0: r = av;
            1: r = bv;
            2: r = 255 - av;
            3: r = 255 - bv;
            4, 5: begin
                s = av + bv + ((op == 5) ? mc : 0);
                r = s % 256; c = (s > 255);
                s = sg(av) + sg(bv) + ((op == 5) ? mc : 0);
                o = (s > 127 || s < -128);
                rtag = "R2"; ctag = "R3"; otag = "R4";
            end
            6: begin
                r = (av - bv + 256) % 256; c = (av < bv);
                s = sg(av) - sg(bv);
                o = (s > 127 || s < -128);
                rtag = "R2"; ctag = "R3"; otag = "R4";
            end
            7: r = av & bv;
            8: r = av | bv;
            9: r = av ^ bv;
            10: begin r = (av * 2) % 256; c = av / 128; rtag = "R5"; ctag = "R5"; end
            11: begin r = av / 2; c = av % 2; rtag = "R5"; ctag = "R5"; end
            12: begin
                r = (av * 2) % 256; c = av / 128;
                o = (sg(av) * 2 > 127 || sg(av) * 2 < -128);
                rtag = "R5"; ctag = "R5"; otag = "R6";
            end
            13: begin r = av / 2 + ((av >= 128) ? 128 : 0); c = av % 2; o = 0;
                      rtag = "R5"; ctag = "R5"; otag = "R6"; end
            14: begin r = (av * 2) % 256 + av / 128; c = av / 128; rtag = "R5"; ctag = "R5"; end
            default: begin r = av / 2 + (av % 2) * 128; c = av % 2; rtag = "R5"; ctag = "R5"; end
        endcase
        chk(rtag, int'(result), r, op, av, bv);
        ztag = "R7";
        if (rs) begin
            mz = 0; mc = 0; mn = 0; mo = 0;
            ztag = "R10"; ctag = "R10"; otag = "R10";
        end else if (we) begin
            mz = (r == 0); mn = (r >= 128); mc = c; mo = o;
        end else begin
            ztag = "R9"; ctag = "R9"; otag = "R9";
        end
        @(negedge clk);
        chk(ztag, int'(flag_z), mz, op, av, bv);
        chk(ztag, int'(flag_n), mn, op, av, bv);
        chk(ctag, int'(flag_c), mc, op, av, bv);
        chk(otag, int'(flag_o), mo, op, av, bv);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state (R10), then reset overriding write enable (R10)
        step(0, 0, 0, 1'b0, 1'b1);
        step(4, 255, 255, 1'b1, 1'b1);
        // known carry states feeding add-with-carry (R2)
        step(4, 200, 100, 1'b1, 1'b0);
        step(5, 1, 1, 1'b1, 1'b0);
        step(5, 1, 1, 1'b1, 1'b0);
        // full sweep: every code, every A, ten B values
        for (int op = 0; op < 16; op++) begin
            for (int av = 0; av < 256; av++) begin
                for (int i = 0; i < 10; i++) begin
                    step(op, av, pick_b(av, i), ((av + i) % 5) != 0,
                         (av == 37 && i == 3));
                end
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule